// File: doc/BRIEF.md
# Multiplexed LCD Segment Waveform Sequencer

This block produces the digital drive pattern for a segment LCD with up to 40 segment pins and up to 4 common pins. Software writes a small bank of registers over a simple write port. The registers select the multiplex depth, the bias, blanking, an optional reset phase, blinking, the slot timing, the per-pin drive enables and the per-pin segment data. The block runs on the low-frequency clock. It divides that clock down to a half-slot rate and walks the active commons, giving each common a positive half and a negative half.

For every pin in every cycle, the block outputs an enable and a 2-bit level index. An external analog stage turns each index into a voltage: code 0 is ground and code 3 is the full LCD voltage. With 1/3 bias, codes 1 and 2 are one third and two thirds of that voltage. With 1/2 bias, code 1 is half of it and code 2 is not used. A disabled pin always reports code 0. In the negative half, every code is mirrored, so the cell sees no net DC.

Register map (word addresses): 0 control, 1 timing, 2 blink, 3 to 4 segment enables, 5 to 9 segment data.

Top module: `lcd_wave_seq`

## Requirements
- R1: After reset, and while the enable bit (address 0, bit 0) is 0, every common and segment enable is 0 and every level code is 0.
- R2: Address 0 bits [2:1] give the number of commons minus one (0 means 1 common, 3 means 4 commons). Common k is enabled only when k is less than that count, and an unused common shows enable 0 and code 0. The commons are visited in ascending order, and each one occupies two consecutive half-slots: positive, then negative.
- R3: With 1/3 bias (address 0 bit 3 = 0), the positive-half codes are: selected common 3, other active common 1, segment on 0, segment off 2. In the negative half, each code c becomes 3 - c.
- R4: With 1/2 bias (address 0 bit 3 = 1), the positive-half codes are: selected common 3, other active common 1, segment on 0, segment off 3. In the negative half, codes 0 and 3 swap and code 1 stays 1.
- R5: Segment pin 8w+j takes its 4-bit nibble from bits [4j+3:4j] of the data word at address 5+w. Nibble bit k is the on state during common k.
- R6: Address 3 bits [31:0] enable segment pins 0 to 31, and address 4 bits [7:0] enable pins 32 to 39. A pin whose bit is 0 shows enable 0 and code 0.
- R7: Blank (address 0 bit 4) sets every enable and every code to 0 from the cycle after the write, whatever the data or the mode.
- R8: One half-slot lasts 2^P*(D+1) clock cycles, where P is address 1 bits [13:12] and D is address 1 bits [9:0]. The first half-slot (common 0, positive) begins one cycle after the cycle in which the enable write lands.
- R9: With address 0 bit 5 set, the first R+1 cycles of every half-slot show code 0 on all enabled pins, with the enables kept, where R is address 0 bits [8:6]. Normal codes follow for the rest of the half-slot.
- R10: Address 2 bits [7:0] mark segment pins 0 to 7 as blinking, and bits [11:8] hold an exponent n. For n from 2 to 13, a marked pin is forced off in every frame whose frame count has bit n-1 set. The frame count is 0 in the first frame. Any other value of n disables blinking.
- R11: New values of the common count, the bias, D and P, written while the block runs, take effect only at the next frame boundary.
- R12: Clearing the enable bit disables every pin from the second cycle after the write and resets the sequencer, so the next enable starts again at common 0, positive half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| com_en | output | 4 | Per-common drive enable |
| com_lvl | output | 8 | Per-common level code, 2 bits per common |
| seg_en | output | 40 | Per-segment drive enable |
| seg_lvl | output | 80 | Per-segment level code, 2 bits per pin |

## Verification
The assertions assume that the write port stays quiet during reset. They also assume that any reset-phase length in use is shorter than the half-slot, so each half-slot still has cycles with normal codes. The stimulus always programs the timing before it sets the enable bit. It picks reset-phase lengths well below the half-slot length. It changes the common count while the block runs only in the test that checks the frame-boundary update.

// File: rtl/lcd_seq_pkg.sv
// Shared level-code helpers for the LCD waveform sequencer.
// Codes: 0 = ground, 3 = full LCD voltage, 1/2 = intermediate rails.
package lcd_seq_pkg;

    typedef logic [1:0] lvl_t;

    // Mirror a positive-half code into the negative half for the chosen bias.
    function automatic lvl_t mirror_lvl(input lvl_t code, input logic half_bias);
        if (half_bias)
            return (code == 2'd3) ? 2'd0 : (code == 2'd0) ? 2'd3 : code;
        else
            return ~code;
    endfunction

    // Code driven on an active common.
    function automatic lvl_t com_code(input logic sel, input logic neg, input logic half_bias);
        lvl_t pos;
        pos = sel ? 2'd3 : 2'd1;
        return neg ? mirror_lvl(pos, half_bias) : pos;
    endfunction

    // Code driven on an enabled segment.
    function automatic lvl_t seg_code(input logic on, input logic neg, input logic half_bias);
        lvl_t pos;
        pos = on ? 2'd0 : (half_bias ? 2'd3 : 2'd2);
        return neg ? mirror_lvl(pos, half_bias) : pos;
    endfunction

endpackage

// File: rtl/lcd_seq_regs.sv
// Register bank of the sequencer.
// Holds all settings. The timing and mode fields are copied into shadow
// registers while idle and at each frame boundary.
// Assumes NUM_SEG*NUM_COM is a multiple of 32 or that the last word is partial.
module lcd_seq_regs #(
    parameter int NUM_SEG = 40,
    parameter int NUM_COM = 4,
    parameter int COM_W   = 2,
    parameter int DIV_W   = 10,
    parameter int RPH_W   = 3,
    parameter int BLK_W   = 8,
    parameter int EXP_W   = 4,
    parameter int ADDR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic                       frame_end,
    output logic                       run,
    output logic [COM_W-1:0]           mux_act,
    output logic                       hb_act,
    output logic [DIV_W-1:0]           div_act,
    output logic [1:0]                 pre_act,
    output logic                       blank,
    output logic                       rph_en,
    output logic [RPH_W-1:0]           rph_len,
    output logic [BLK_W-1:0]           blk_mask,
    output logic [EXP_W-1:0]           blk_exp,
    output logic [NUM_SEG-1:0]         seg_mask,
    output logic [NUM_SEG*NUM_COM-1:0] seg_data
);
    localparam int MASK_WORDS = (NUM_SEG + 31) / 32;
    localparam int DATA_BITS  = NUM_SEG * NUM_COM;
    localparam int DATA_WORDS = (DATA_BITS + 31) / 32;
    localparam int A_CTRL     = 0;
    localparam int A_TIME     = 1;
    localparam int A_BLINK    = 2;
    localparam int A_MASK     = 3;
    localparam int A_DATA     = A_MASK + MASK_WORDS;

    logic             en_q;
    logic [COM_W-1:0] mux_q;
    logic             hb_q;
    logic [DIV_W-1:0] div_q;
    logic [1:0]       pre_q;

    // Control word: enable, mode, bias, blank, reset phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mux_q   <= '0;
            hb_q    <= 1'b0;
            blank   <= 1'b0;
            rph_en  <= 1'b0;
            rph_len <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) begin
            en_q    <= wr_data[0];
            mux_q   <= wr_data[1 +: COM_W];
            hb_q    <= wr_data[3];
            blank   <= wr_data[4];
            rph_en  <= wr_data[5];
            rph_len <= wr_data[6 +: RPH_W];
        end
    end

    // Timing word: divider and prescale code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            pre_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_TIME)) begin
            div_q <= wr_data[DIV_W-1:0];
            pre_q <= wr_data[13:12];
        end
    end

    // Blink word: pin mask and rate exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_mask <= '0;
            blk_exp  <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_BLINK)) begin
            blk_mask <= wr_data[BLK_W-1:0];
            blk_exp  <= wr_data[8 +: EXP_W];
        end
    end

    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
        localparam int LO  = 32 * w;
        localparam int WID = (NUM_SEG - LO > 32) ? 32 : NUM_SEG - LO;
        // Segment enable word w.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_mask[LO +: WID] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_MASK + w))
                seg_mask[LO +: WID] <= wr_data[WID-1:0];
        end
    end

    for (genvar w = 0; w < DATA_WORDS; w++) begin : g_data
        localparam int LO  = 32 * w;
        localparam int WID = (DATA_BITS - LO > 32) ? 32 : DATA_BITS - LO;
        // Segment data word w.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_data[LO +: WID] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_DATA + w))
                seg_data[LO +: WID] <= wr_data[WID-1:0];
        end
    end

    // Run flag trails the enable bit by one cycle so shadows load first.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= en_q;
    end

    // Shadow copy of mode and timing, refreshed while idle or at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_act <= '0;
            hb_act  <= 1'b0;
            div_act <= '0;
            pre_act <= '0;
        end else if (!run || frame_end) begin
            mux_act <= mux_q;
            hb_act  <= hb_q;
            div_act <= div_q;
            pre_act <= pre_q;
        end
    end
endmodule

// File: rtl/lcd_seq_timebase.sv
// Slot timebase: prescaler, programmable divider and reset-phase counter.
// Emits a one-cycle slot_tick in the last cycle of each half-slot.
// Assumes the reset-phase length is shorter than the half-slot.
module lcd_seq_timebase #(
    parameter int DIV_W = 10,
    parameter int RPH_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       pre_code,
    input  logic [DIV_W-1:0] div_val,
    input  logic             rph_en,
    input  logic [RPH_W-1:0] rph_len,
    output logic             slot_tick,
    output logic             rph_active
);
    localparam logic [RPH_W:0] RPH_SAT = (RPH_W+1)'(1 << RPH_W);

    logic [2:0]       pre_cnt;
    logic [2:0]       pre_lim;
    logic             pre_tick;
    logic [DIV_W-1:0] div_cnt;
    logic [RPH_W:0]   rph_cnt;

    // Last prescaler count for the selected power of two.
    always_comb begin
        case (pre_code)
            2'd0:    pre_lim = 3'd0;
            2'd1:    pre_lim = 3'd1;
            2'd2:    pre_lim = 3'd3;
            default: pre_lim = 3'd7;
        endcase
    end

    assign pre_tick  = (pre_cnt == pre_lim);
    assign slot_tick = run && pre_tick && (div_cnt == div_val);

    // Prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_cnt <= '0;
        else if (pre_tick)  pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 3'd1;
    end

    // Divider counter, advanced by prescaler ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                 div_cnt <= '0;
        else if (pre_tick && div_cnt == div_val) div_cnt <= '0;
        else if (pre_tick)                  div_cnt <= div_cnt + 1'b1;
    end

    // Cycles since half-slot start, saturating past the longest reset phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || slot_tick) rph_cnt <= '0;
        else if (rph_cnt != RPH_SAT)     rph_cnt <= rph_cnt + 1'b1;
    end

    assign rph_active = rph_en && run && (rph_cnt <= {1'b0, rph_len});
endmodule

// File: rtl/lcd_seq_sequencer.sv
// Common/polarity sequencer and frame counter.
// Visits commons 0..mux, positive then negative half each; counts frames.
module lcd_seq_sequencer #(
    parameter int COM_W   = 2,
    parameter int FRAME_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               slot_tick,
    input  logic [COM_W-1:0]   mux,
    output logic [COM_W-1:0]   com_idx,
    output logic               neg_half,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               frame_end
);
    assign frame_end = slot_tick && neg_half && (com_idx == mux);

    // Step polarity, common index and frame count on each half-slot end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            com_idx   <= '0;
            neg_half  <= 1'b0;
            frame_cnt <= '0;
        end else if (slot_tick) begin
            neg_half <= ~neg_half;
            if (neg_half)
                com_idx <= frame_end ? '0 : com_idx + 1'b1;
            if (frame_end)
                frame_cnt <= frame_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_seq_pins.sv
// Pin encoder: turns sequencer state and settings into per-pin enables and
// level codes. Purely combinational; blank and idle override everything.
module lcd_seq_pins
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 40,
    parameter int NUM_COM = 4,
    parameter int COM_W   = 2,
    parameter int BLK_W   = 8,
    parameter int EXP_W   = 4,
    parameter int FRAME_W = 13
) (
    input  logic                       run,
    input  logic                       blank,
    input  logic                       rph_active,
    input  logic                       half_bias,
    input  logic [COM_W-1:0]           mux,
    input  logic [COM_W-1:0]           com_idx,
    input  logic                       neg_half,
    input  logic [FRAME_W-1:0]         frame_cnt,
    input  logic [BLK_W-1:0]           blk_mask,
    input  logic [EXP_W-1:0]           blk_exp,
    input  logic [NUM_SEG-1:0]         seg_mask,
    input  logic [NUM_SEG*NUM_COM-1:0] seg_data,
    output logic [NUM_COM-1:0]         com_en,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [NUM_SEG-1:0]         seg_en,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);
    localparam int EXP_MIN = 2;

    logic blink_off;
    logic live;

    // Blink phase: selected frame-count bit for a valid exponent.
    always_comb begin
        blink_off = 1'b0;
        for (int i = EXP_MIN; i <= FRAME_W; i++)
            if (blk_exp == EXP_W'(i)) blink_off = frame_cnt[i-1];
    end

    assign live = run && !blank;

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        logic act;
        assign act        = live && (COM_W'(k) <= mux);
        assign com_en[k]  = act;
        assign com_lvl[2*k +: 2] = (!act || rph_active) ? 2'd0
                                 : com_code(com_idx == COM_W'(k), neg_half, half_bias);
    end

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        logic [NUM_COM-1:0] nib;
        logic               act;
        logic               on;
        assign nib = seg_data[j*NUM_COM +: NUM_COM];
        assign act = live && seg_mask[j];
        if (j < BLK_W) begin : g_blink
            assign on = nib[com_idx] && !(blk_mask[j] && blink_off);
        end else begin : g_plain
            assign on = nib[com_idx];
        end
        assign seg_en[j]         = act;
        assign seg_lvl[2*j +: 2] = (!act || rph_active) ? 2'd0
                                 : seg_code(on, neg_half, half_bias);
    end
endmodule

// File: rtl/lcd_wave_seq.sv
// Top of the multiplexed LCD waveform sequencer.
// Clocked by the low-frequency clock; registers written through a plain
// strobe/address/data port; outputs are per-pin enables and level codes.
module lcd_wave_seq #(
    parameter int NUM_SEG = 40,
    parameter int NUM_COM = 4,
    parameter int DIV_W   = 10,
    parameter int RPH_W   = 3,
    parameter int BLK_W   = 8,
    parameter int EXP_W   = 4,
    parameter int ADDR_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    output logic [NUM_COM-1:0]     com_en,
    output logic [2*NUM_COM-1:0]   com_lvl,
    output logic [NUM_SEG-1:0]     seg_en,
    output logic [2*NUM_SEG-1:0]   seg_lvl
);
    localparam int COM_W   = $clog2(NUM_COM);
    localparam int FRAME_W = (1 << EXP_W) - 3;

    logic                       run;
    logic [COM_W-1:0]           mux_act;
    logic                       hb_act;
    logic [DIV_W-1:0]           div_act;
    logic [1:0]                 pre_act;
    logic                       blank;
    logic                       rph_en;
    logic [RPH_W-1:0]           rph_len;
    logic [BLK_W-1:0]           blk_mask;
    logic [EXP_W-1:0]           blk_exp;
    logic [NUM_SEG-1:0]         seg_mask;
    logic [NUM_SEG*NUM_COM-1:0] seg_data;
    logic                       slot_tick;
    logic                       rph_active;
    logic [COM_W-1:0]           com_idx;
    logic                       neg_half;
    logic [FRAME_W-1:0]         frame_cnt;
    logic                       frame_end;

    lcd_seq_regs #(
        .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .COM_W(COM_W), .DIV_W(DIV_W),
        .RPH_W(RPH_W), .BLK_W(BLK_W), .EXP_W(EXP_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .run(run),
        .mux_act(mux_act), .hb_act(hb_act), .div_act(div_act),
        .pre_act(pre_act), .blank(blank), .rph_en(rph_en),
        .rph_len(rph_len), .blk_mask(blk_mask), .blk_exp(blk_exp),
        .seg_mask(seg_mask), .seg_data(seg_data)
    );

    lcd_seq_timebase #(.DIV_W(DIV_W), .RPH_W(RPH_W)) u_time (
        .clk(clk), .rst_n(rst_n), .run(run), .pre_code(pre_act),
        .div_val(div_act), .rph_en(rph_en), .rph_len(rph_len),
        .slot_tick(slot_tick), .rph_active(rph_active)
    );

    lcd_seq_sequencer #(.COM_W(COM_W), .FRAME_W(FRAME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .slot_tick(slot_tick),
        .mux(mux_act), .com_idx(com_idx), .neg_half(neg_half),
        .frame_cnt(frame_cnt), .frame_end(frame_end)
    );

    lcd_seq_pins #(
        .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .COM_W(COM_W),
        .BLK_W(BLK_W), .EXP_W(EXP_W), .FRAME_W(FRAME_W)
    ) u_pins (
        .run(run), .blank(blank), .rph_active(rph_active),
        .half_bias(hb_act), .mux(mux_act), .com_idx(com_idx),
        .neg_half(neg_half), .frame_cnt(frame_cnt), .blk_mask(blk_mask),
        .blk_exp(blk_exp), .seg_mask(seg_mask), .seg_data(seg_data),
        .com_en(com_en), .com_lvl(com_lvl), .seg_en(seg_en), .seg_lvl(seg_lvl)
    );
endmodule

// File: rtl/lcd_seq_chk.sv
// Assertion checker for lcd_wave_seq, attached by bind below.
// Assumes inputs are quiet during reset.
module lcd_seq_chk #(
    parameter int NUM_SEG = 40,
    parameter int NUM_COM = 4,
    parameter int COM_W   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic                 blank,
    input logic [COM_W-1:0]     com_idx,
    input logic                 neg_half,
    input logic [NUM_COM-1:0]   com_en,
    input logic [2*NUM_COM-1:0] com_lvl,
    input logic [NUM_SEG-1:0]   seg_en,
    input logic [2*NUM_SEG-1:0] seg_lvl
);
    // R12
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (com_en == '0 && seg_en == '0));

    // R7
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (com_en == '0 && seg_en == '0));

    // R2
    com_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((com_en & (com_en + 1'b1)) == '0));

    // R2
    com_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(com_idx)) |-> $past(neg_half));

    for (genvar k = 0; k < NUM_COM; k++) begin : g_c
        // R2
        com_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !com_en[k] |-> (com_lvl[2*k +: 2] == 2'd0));
    end

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_s
        // R6
        seg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !seg_en[j] |-> (seg_lvl[2*j +: 2] == 2'd0));
    end
endmodule

bind lcd_wave_seq lcd_seq_chk #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .COM_W(COM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .blank(blank),
    .com_idx(com_idx), .neg_half(neg_half), .com_en(com_en),
    .com_lvl(com_lvl), .seg_en(seg_en), .seg_lvl(seg_lvl)
);

// File: tb/lcd_wave_seq_tb.sv
`timescale 1ns/1ps
module lcd_wave_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  com_en;
    logic [7:0]  com_lvl;
    logic [39:0] seg_en;
    logic [79:0] seg_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_wave_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .com_en(com_en), .com_lvl(com_lvl),
        .seg_en(seg_en), .seg_lvl(seg_lvl)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       bias;
        logic [3:0] nib;
        logic [2:0] slot;
        logic [3:0] cen;
        logic [1:0] c0;
        logic [1:0] c1;
        logic [1:0] s0;
    } vec_t;

    // mode, bias, pin0 nibble, half-slot, commons enabled, com0, com1, seg0
    localparam vec_t VECS [10] = '{
        '{2'd0, 1'b0, 4'h1, 3'd0, 4'b0001, 2'd3, 2'd0, 2'd0},
        '{2'd0, 1'b0, 4'h1, 3'd1, 4'b0001, 2'd0, 2'd0, 2'd3},
        '{2'd1, 1'b1, 4'h2, 3'd0, 4'b0011, 2'd3, 2'd1, 2'd3},
        '{2'd1, 1'b1, 4'h2, 3'd3, 4'b0011, 2'd1, 2'd0, 2'd3},
        '{2'd2, 1'b0, 4'h4, 3'd2, 4'b0111, 2'd1, 2'd3, 2'd2},
        '{2'd2, 1'b0, 4'h4, 3'd5, 4'b0111, 2'd2, 2'd2, 2'd3},
        '{2'd3, 1'b0, 4'h8, 3'd6, 4'b1111, 2'd1, 2'd1, 2'd0},
        '{2'd3, 1'b0, 4'h8, 3'd1, 4'b1111, 2'd0, 2'd2, 2'd1},
        '{2'd3, 1'b1, 4'h0, 3'd2, 4'b1111, 2'd1, 2'd3, 2'd3},
        '{2'd0, 1'b1, 4'h0, 3'd1, 4'b0001, 2'd0, 2'd0, 2'd0}
    };

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input logic [1:0] mode, input logic bias,
                                         input logic blk, input logic rph,
                                         input logic [2:0] len);
        return {23'd0, len, rph, blk, bias, mode, 1'b1};
    endfunction

    // Enable write, then step to cycle 0 of the first half-slot.
    task automatic start(input logic [31:0] c);
        wr(4'd0, c);
        @(negedge clk);
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 enables", {40'd0, com_en, seg_en[35:0]}, 80'd0);
        chk("R1 levels", {com_lvl, seg_lvl[71:0]}, 80'd0);

        // Vector table: R2 R3 R4 R5
        for (int i = 0; i < 10; i++) begin
            wr(4'd0, 32'd0);
            wr(4'd1, 32'd1);
            wr(4'd3, 32'd1);
            wr(4'd5, {28'd0, VECS[i].nib});
            start(ctrl(VECS[i].mode, VECS[i].bias, 1'b0, 1'b0, 3'd0));
            adv(int'(VECS[i].slot) * 2 + 1);
            chk($sformatf("R2 vec%0d com_en", i), 80'(com_en), 80'(VECS[i].cen));
            chk($sformatf("R3/R4 vec%0d com0", i), 80'(com_lvl[1:0]), 80'(VECS[i].c0));
            chk($sformatf("R3/R4 vec%0d com1", i), 80'(com_lvl[3:2]), 80'(VECS[i].c1));
            chk($sformatf("R5 vec%0d seg0", i), 80'(seg_lvl[1:0]), 80'(VECS[i].s0));
            chk($sformatf("R6 vec%0d seg_en", i), 80'(seg_en), 80'(40'd1));
        end

        // R8: prescale 2, divider 3 -> 6 cycles per half-slot
        wr(4'd0, 32'd0);
        wr(4'd1, 32'h0000_1002);
        start(ctrl(2'd1, 1'b0, 1'b0, 1'b0, 3'd0));
        chk("R8 cycle0", 80'(com_lvl[1:0]), 80'd3);
        adv(5);
        chk("R8 cycle5", 80'(com_lvl[1:0]), 80'd3);
        adv(1);
        chk("R8 cycle6", 80'(com_lvl[1:0]), 80'd0);
        adv(6);
        chk("R8 cycle12", 80'(com_lvl[3:2]), 80'd3);

        // R9: reset phase of 3 cycles in a 6-cycle half-slot
        wr(4'd0, 32'd0);
        wr(4'd1, 32'd5);
        start(ctrl(2'd1, 1'b0, 1'b0, 1'b1, 3'd2));
        chk("R9 cycle0 en", 80'(com_en), 80'b0011);
        adv(2);
        chk("R9 cycle2", 80'(com_lvl[1:0]), 80'd0);
        adv(1);
        chk("R9 cycle3", 80'(com_lvl[1:0]), 80'd3);
        adv(3);
        chk("R9 cycle6", 80'(com_lvl[3:2]), 80'd0);
        adv(3);
        chk("R9 cycle9", 80'(com_lvl[3:2]), 80'd2);

        // R10: blink exponent 2 on pin 0, frames of 4 cycles
        wr(4'd0, 32'd0);
        wr(4'd1, 32'd1);
        wr(4'd3, 32'd3);
        wr(4'd5, 32'h11);
        wr(4'd2, 32'h0000_0201);
        start(ctrl(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        adv(1);
        chk("R10 frame0 seg0", 80'(seg_lvl[1:0]), 80'd0);
        adv(8);
        chk("R10 frame2 seg0", 80'(seg_lvl[1:0]), 80'd2);
        chk("R10 frame2 seg1", 80'(seg_lvl[3:2]), 80'd0);
        adv(8);
        chk("R10 frame4 seg0", 80'(seg_lvl[1:0]), 80'd0);
        wr(4'd0, 32'd0);
        wr(4'd2, 32'h0000_0E01);
        start(ctrl(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        adv(9);
        chk("R10 bad exp seg0", 80'(seg_lvl[1:0]), 80'd0);
        wr(4'd2, 32'd0);

        // R6: pin 35 only
        wr(4'd0, 32'd0);
        wr(4'd3, 32'd0);
        wr(4'd4, 32'h8);
        wr(4'd9, 32'h0000_1000);
        start(ctrl(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        adv(1);
        chk("R6 seg_en", 80'(seg_en), 80'(40'h08_0000_0000));
        chk("R6 pin35 on", 80'(seg_lvl[71:70]), 80'd0);
        adv(2);
        chk("R6 pin35 neg", 80'(seg_lvl[71:70]), 80'd3);

        // R7: blank while running
        wr(4'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b0, 3'd0));
        chk("R7 enables", {40'd0, com_en, seg_en[35:0]} | 80'(seg_en), 80'd0);
        chk("R7 levels", {com_lvl, seg_lvl[71:0]} | 80'(seg_lvl), 80'd0);

        // R11: mode change mid-frame waits for the frame boundary
        wr(4'd0, 32'd0);
        wr(4'd3, 32'd1);
        start(ctrl(2'd3, 1'b0, 1'b0, 1'b0, 3'd0));
        adv(3);
        wr(4'd0, ctrl(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        adv(1);
        chk("R11 old mode kept", 80'(com_en), 80'b1111);
        adv(12);
        chk("R11 new mode", 80'(com_en), 80'b0001);

        // R12: disable, then restart from common 0
        wr(4'd0, 32'd0);
        adv(1);
        chk("R12 off", 80'(com_en) | 80'(seg_en), 80'd0);
        start(ctrl(2'd1, 1'b0, 1'b0, 1'b0, 3'd0));
        chk("R12 restart en", 80'(com_en), 80'b0011);
        chk("R12 restart com0", 80'(com_lvl), 80'h07);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule